// File: doc/BRIEF.md
# Receive CRC Start Sequencer

This block decides when the receive-side CRC register of a CAN controller is cleared back to its start value and when it accumulates bits. A protocol-control state machine feeds it the present protocol phase, the index of the current interframe bit, a one-cycle sample-point strobe, the sampled bus level and a flag that marks the sample point on which integration or reintegration finishes. From these inputs it drives a clear pulse, an accumulate enable and a pulse that presets the destuffer's equal-bit counter to one. A 15-bit CRC register in the block shows the effect of these outputs.

Clearing happens only on explicit protocol conditions and never on an edge of the enable, so the destuffing datapath needs no bypass multiplexer. Clearing is done on the first two interframe bits. It is never done on the last one, because a dominant level sampled there is already a start of frame and counts as the first CRC bit. The register is also cleared when the node joins the bus after integration. In idle, accumulation starts only when a dominant level is seen at a sample point.

Top module: `crc_start_seq`

## Requirements
- R1: In the interframe phase (phase code 1) with bit index 0 or 1, a sample point raises `crcInit` in that same cycle, and `crcValue` reads 0 after the next clock edge.
- R2: In the interframe phase at bit index 2, `crcInit` stays low. A dominant level (`rxBit` = 0) sampled there is a start of frame and is shifted into the CRC as its first bit.
- R3: In the integration phase (code 2) or the reintegration phase (code 3), a sample point with `joinDone` high raises `crcInit`, and `crcValue` reads 0 after the edge.
- R4: In idle (code 0), `crcEnable` rises only after a sample point that sees a dominant level. A dominant level without a sample point changes neither `crcEnable` nor `crcValue`.
- R5: `sameBitRst` pulses in exactly the sample-point cycle in which a start of frame is taken, whether in idle or in interframe bit 2.
- R6: While `crcEnable` is high and the phase is in-frame (code 4), each sample point shifts `rxBit` into the CRC using the polynomial 0x4599 (next = shifted value XOR the polynomial when `rxBit` XOR the old MSB is 1). Cycles without a sample point leave the CRC unchanged.
- R7: When the phase leaves in-frame (for example to the frame tail, code 5), `crcEnable` drops after the edge and `crcValue` holds.
- R8: `crcInit` is high only in a sample-point cycle, and a clear and a CRC step never fall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pcPhase | input | 3 | Protocol phase: 0 idle, 1 interframe, 2 integration, 3 reintegration, 4 in-frame, 5 frame tail |
| ifsIdx | input | 2 | Index of the interframe bit (0..2) |
| samplePt | input | 1 | One-cycle sample-point strobe |
| rxBit | input | 1 | Sampled bus level, 0 = dominant |
| joinDone | input | 1 | Integration or reintegration completes at this sample point |
| crcInit | output | 1 | CRC clear pulse |
| crcEnable | output | 1 | CRC accumulation active |
| sameBitRst | output | 1 | Presets the destuffer equal-bit counter to one |
| crcValue | output | 15 | Current CRC register |

## Verification
A wrong clear decision shows one edge later as a stale or zeroed `crcValue`, and in every case it corrupts the CRC compared at the end of the frame. A start of frame that is missed or taken at the wrong time shows at once on `sameBitRst`. It also shows after the edge on `crcEnable`, and the frame's final CRC then misses or gains a bit. The bench compares the final CRC of back-to-back frames against a software model. These frames include a start of frame in interframe bit 2 and one taken right after reintegration.

// File: rtl/crc_start_pkg.sv
package crc_start_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_IFS     = 3'd1,
    PH_INTEG   = 3'd2,
    PH_REINTEG = 3'd3,
    PH_FRAME   = 3'd4,
    PH_TAIL    = 3'd5
  } phase_e;

  typedef struct packed {
    logic load;
    logic shift;
  } crcCtl_t;

  localparam logic DOMINANT = 1'b0;
endpackage

// File: rtl/crc_start_ctrl.sv
module crc_start_ctrl
  import crc_start_pkg::*;
#(
  parameter int IFS_LEN = 3,
  localparam int IDX_W = (IFS_LEN > 1) ? $clog2(IFS_LEN) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  phase_e           phase,
  input  logic [IDX_W-1:0] ifsIdx,
  input  logic             samplePt,
  input  logic             rxBit,
  input  logic             joinDone,
  output crcCtl_t          ctl,
  output logic             enable,
  output logic             sameBitRst
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IFS_LEN - 1);

  logic enReg;
  logic sofWindow;
  logic sofHit;
  logic initHit;
  logic joinPhase;

  assign joinPhase = (phase == PH_INTEG) || (phase == PH_REINTEG);
  assign sofWindow = (phase == PH_IDLE) || ((phase == PH_IFS) && (ifsIdx == LAST_IDX));
  assign sofHit    = samplePt && sofWindow && (rxBit == DOMINANT);
  assign initHit   = samplePt && (((phase == PH_IFS) && (ifsIdx < LAST_IDX))
                                  || (joinPhase && joinDone));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg <= 1'b0;
    end else if (sofHit) begin
      enReg <= 1'b1;
    end else if (phase != PH_FRAME) begin
      enReg <= 1'b0;
    end
  end

  always_comb begin
    ctl.load  = initHit;
    ctl.shift = sofHit || (samplePt && enReg && (phase == PH_FRAME));
  end

  assign enable     = enReg;
  assign sameBitRst = sofHit;

  // R8: a clear only ever comes with a sample-point strobe
  a_r8_load_on_sample: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> samplePt);

  // R5: a start-of-frame preset is followed by active accumulation
  a_r5_preset_enables: assert property (@(posedge clk) disable iff (!rstN)
    sameBitRst |=> enable);

  // R4: without a strobe, an idle block cannot start accumulating
  a_r4_idle_needs_sample: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !samplePt) |=> !enable);

  // R7: leaving the frame drops the enable
  a_r7_leave_frame: assert property (@(posedge clk) disable iff (!rstN)
    ((phase != PH_FRAME) && !sameBitRst) |=> !enable);
endmodule

// File: rtl/crc_start_dp.sv
module crc_start_dp
  import crc_start_pkg::*;
#(
  parameter int              CRC_W = 15,
  parameter logic [CRC_W-1:0] POLY  = 15'h4599,
  parameter logic [CRC_W-1:0] INIT  = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  crcCtl_t          ctl,
  input  logic             dataBit,
  output logic [CRC_W-1:0] crc
);
  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] crcNext;
  logic             fb;

  always_comb begin
    fb      = dataBit ^ crcReg[CRC_W-1];
    crcNext = {crcReg[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg <= INIT;
    end else if (ctl.load) begin
      crcReg <= INIT;
    end else if (ctl.shift) begin
      crcReg <= crcNext;
    end
  end

  assign crc = crcReg;

  // R1 / R3: a clear leaves the start value in the register
  a_r1_load_gives_init: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (crc == INIT));

  // R6: no step and no clear means the register holds
  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.shift) |=> $stable(crc));

  // R8: the control never asks for a clear and a step together
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.load && ctl.shift));
endmodule

// File: rtl/crc_start_seq.sv
module crc_start_seq
  import crc_start_pkg::*;
#(
  parameter int               CRC_W   = 15,
  parameter logic [CRC_W-1:0] POLY    = 15'h4599,
  parameter logic [CRC_W-1:0] INIT    = '0,
  parameter int               IFS_LEN = 3,
  localparam int              IDX_W   = (IFS_LEN > 1) ? $clog2(IFS_LEN) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       pcPhase,
  input  logic [IDX_W-1:0] ifsIdx,
  input  logic             samplePt,
  input  logic             rxBit,
  input  logic             joinDone,
  output logic             crcInit,
  output logic             crcEnable,
  output logic             sameBitRst,
  output logic [CRC_W-1:0] crcValue
);
  crcCtl_t ctl;

  crc_start_ctrl #(.IFS_LEN(IFS_LEN)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .phase      (phase_e'(pcPhase)),
    .ifsIdx     (ifsIdx),
    .samplePt   (samplePt),
    .rxBit      (rxBit),
    .joinDone   (joinDone),
    .ctl        (ctl),
    .enable     (crcEnable),
    .sameBitRst (sameBitRst)
  );

  crc_start_dp #(.CRC_W(CRC_W), .POLY(POLY), .INIT(INIT)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .dataBit (rxBit),
    .crc     (crcValue)
  );

  assign crcInit = ctl.load;
endmodule

// File: tb/test_crc_start_seq.sv
module test_crc_start_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  pcPhase = 3'd0;
  logic [1:0]  ifsIdx = 2'd0;
  logic        samplePt = 1'b0;
  logic        rxBit = 1'b1;
  logic        joinDone = 1'b0;
  logic        crcInit, crcEnable, sameBitRst;
  logic [14:0] crcValue;

  int nChecks = 0;
  int nFails  = 0;
  logic [14:0] expQ[$];
  logic        finished = 1'b0;

  always #10 clk = ~clk;

  crc_start_seq i_crc_start_seq (
    .clk(clk), .rstN(rstN), .pcPhase(pcPhase), .ifsIdx(ifsIdx),
    .samplePt(samplePt), .rxBit(rxBit), .joinDone(joinDone),
    .crcInit(crcInit), .crcEnable(crcEnable), .sameBitRst(sameBitRst),
    .crcValue(crcValue)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [14:0] stepRef(input logic [14:0] c, input logic b);
    logic f;
    f = b ^ c[14];
    return {c[13:0], 1'b0} ^ (f ? 15'h4599 : 15'h0);
  endfunction

  function automatic logic [14:0] frameRef(input logic [31:0] pat, input int n);
    logic [14:0] c;
    c = stepRef(15'h0, 1'b0);
    for (int i = n - 1; i >= 0; i--) c = stepRef(c, pat[i]);
    return c;
  endfunction

  task automatic drive(input logic [2:0] ph, input logic [1:0] idx, input logic sp,
                       input logic rx, input logic jd);
    @(negedge clk);
    pcPhase = ph; ifsIdx = idx; samplePt = sp; rxBit = rx; joinDone = jd;
    #1;
  endtask

  // SOF already applied by caller; sends payload bits and a tail bit, then queues result
  task automatic sendBody(input logic [31:0] pat, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      drive(3'd4, 2'd0, 1'b1, pat[i], 1'b0);
      drive(3'd4, 2'd0, 1'b0, ~pat[i], 1'b0);
    end
    drive(3'd5, 2'd0, 1'b1, 1'b1, 1'b0);
    drive(3'd5, 2'd0, 1'b0, 1'b1, 1'b0);
    check("R7 enable drops after frame", crcEnable, 1'b0);
    expQ.push_back(frameRef(pat, n));
  endtask

  // monitor: compares queued CRCs against the register
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (expQ.size() > 0) begin
        logic [14:0] e;
        e = expQ.pop_front();
        check("R6 frame CRC", crcValue, e);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [14:0] held;
    repeat (3) @(posedge clk);
    #1;
    check("reset crcValue", crcValue, 15'h0);
    check("reset crcEnable", crcEnable, 1'b0);
    @(negedge clk); rstN = 1'b1;

    // frame A directly from idle: dominant without strobe first (R4)
    drive(3'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check("R4 no preset without strobe", sameBitRst, 1'b0);
    drive(3'd0, 2'd0, 1'b0, 1'b1, 1'b0);
    check("R4 enable stays low", crcEnable, 1'b0);
    check("R4 crc unchanged", crcValue, 15'h0);
    drive(3'd0, 2'd0, 1'b1, 1'b0, 1'b0);
    check("R5 preset on idle SOF", sameBitRst, 1'b1);
    check("R8 no clear on SOF", crcInit, 1'b0);
    drive(3'd4, 2'd0, 1'b0, 1'b1, 1'b0);
    check("R4 enable after sampled dominant", crcEnable, 1'b1);
    check("R5 preset is one cycle", sameBitRst, 1'b0);
    sendBody(32'h0005A3C7, 19);

    // reintegration ends: clear (R3)
    drive(3'd3, 2'd0, 1'b1, 1'b1, 1'b0);
    check("R3 no clear before join", crcInit, 1'b0);
    drive(3'd3, 2'd0, 1'b1, 1'b1, 1'b1);
    check("R3 clear on join", crcInit, 1'b1);
    drive(3'd0, 2'd0, 1'b0, 1'b1, 1'b0);
    check("R3 crc zero after join", crcValue, 15'h0);

    // frame B right after reintegration
    drive(3'd0, 2'd0, 1'b1, 1'b0, 1'b0);
    check("R5 preset after join", sameBitRst, 1'b1);
    sendBody(32'h00012F0B, 17);

    // interframe: strobe-less bit 0 must not clear (R8)
    drive(3'd1, 2'd0, 1'b0, 1'b1, 1'b0);
    check("R8 no clear without strobe", crcInit, 1'b0);
    held = crcValue;
    drive(3'd1, 2'd0, 1'b1, 1'b1, 1'b0);
    check("R8 crc held on strobe-less cycle", crcValue, held);
    check("R1 clear on bit 0", crcInit, 1'b1);
    drive(3'd1, 2'd1, 1'b1, 1'b1, 1'b0);
    check("R1 crc zero after bit 0", crcValue, 15'h0);
    check("R1 clear on bit 1", crcInit, 1'b1);
    drive(3'd1, 2'd2, 1'b1, 1'b0, 1'b0);
    check("R2 no clear on bit 2", crcInit, 1'b0);
    check("R5 preset on bit-2 SOF", sameBitRst, 1'b1);
    sendBody(32'h0003C96E, 18);

    // interframe bit 2 recessive: no SOF, then idle
    drive(3'd1, 2'd0, 1'b1, 1'b1, 1'b0);
    drive(3'd1, 2'd1, 1'b1, 1'b1, 1'b0);
    drive(3'd1, 2'd2, 1'b1, 1'b1, 1'b0);
    check("R2 no clear on recessive bit 2", crcInit, 1'b0);
    check("R2 no preset on recessive bit 2", sameBitRst, 1'b0);
    drive(3'd0, 2'd0, 1'b0, 1'b1, 1'b0);
    check("R2 enable low after recessive bit 2", crcEnable, 1'b0);
    check("R1 crc still zero", crcValue, 15'h0);

    // integration join, then frame D from idle
    drive(3'd2, 2'd0, 1'b1, 1'b1, 1'b1);
    check("R3 clear on integration join", crcInit, 1'b1);
    drive(3'd0, 2'd0, 1'b1, 1'b0, 1'b0);
    check("R5 preset after integration", sameBitRst, 1'b1);
    sendBody(32'h7A5F0C31, 31);

    drive(3'd5, 2'd0, 1'b0, 1'b1, 1'b0);
    drive(3'd5, 2'd0, 1'b0, 1'b1, 1'b0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule